// File: doc/BRIEF.md
# Clock generator configuration slave

This block is the configuration port of a clock generator. An external master reaches a small bank of 8-bit control registers over a two-wire serial bus in the I2C style. The block oversamples the serial clock and data lines with the system clock. It finds start and stop conditions and assembles bytes from them. It answers one fixed 7-bit device address and keeps an 8-bit register pointer that moves forward by one after every data byte, in both write and read bursts.

The register contents leave the block as one flat parallel bus, so the dividers, source selectors and output enables of the chip can use them directly. The registers are volatile: every reset loads the power-on values. A few bits are hard-wired, and writes cannot change them. The data line is never driven high. The block only asserts an open-drain pull-down enable, and the pad pulls the line low while that enable is 1.

Top module: `clkcfg_slave`

## Requirements
- R1: A start condition (data falls while clock is high) aborts any transfer in progress and makes the next byte a device-address byte. A partly received byte that a start cuts off writes nothing.
- R2: The first byte after a start carries the 7-bit device address (default 0x6A) in bits 7:1 and R/W in bit 0, and is sent MSB first. On a mismatch the slave does not acknowledge, and it ignores all traffic until the next start.
- R3: The slave acknowledges a matching address byte, the register-pointer byte and every write data byte by driving the data line low for the whole ninth clock of that byte.
- R4: In a write, the byte after the address byte loads the pointer. Each following data byte is written to the pointer address, and the pointer then increments with 8-bit wrap.
- R5: After a repeated start with R/W=1, the slave sends the register at the pointer MSB first, then the following addresses, for as long as the master acknowledges each byte.
- R6: When the master does not acknowledge a read byte, the slave releases the data line and waits for a stop or a start.
- R7: The implemented addresses are 0x09, 0x0C, 0x12, 0x13, 0x40, 0x41, 0x42, 0x44, 0x45, 0x46 and 0x47. Writes to any other address are acknowledged and discarded, and reads from any other address return 0x00.
- R8: Reset loads 0x13 into 0x09, 0x08 into 0x0C, 0x08 into 0x12, 0x80 into 0x13, 0xC1 into 0x40, 0x20 into 0x41, 0x04 into 0x42, 0x29 into 0x44, 0x4A into 0x45, 0x7F into 0x46 and 0x88 into 0x47.
- R9: Bits 7:5 of 0x40 always read 3'b110, and bits 5:0 of 0x46 always read all ones, whatever is written.
- R10: regs_o carries register k of the R7 list (ascending address, k from 0) on bits 8k+7:8k.
- R11: A stop condition (data rises while clock is high) releases the data line. The pull-down enable changes only after a detected clock fall, start or stop, and the system clock runs at least 8 times the bus clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull-down enable for the data pad; 1 drives the line low |
| regs_o | output | 88 | All implemented registers, packed as R10 gives |

## Verification
The assertions assume that clock and data never change in the same system cycle, that data changes only while the clock is low except at start and stop, and that each bus clock phase lasts several system cycles. The stimulus keeps to this. Each bus quarter period lasts 16 system cycles, and data moves one quarter after a clock fall. The master never moves clock and data on the same edge, and it always declines the last read byte before it sends a stop. The random traffic mixes implemented and unimplemented base addresses so that bursts cross the holes in the map.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/100ps
package clkcfg_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 11;
  localparam int CNT_W    = 4;

  typedef logic [REG_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_ACK_END,
    ST_TX,
    ST_MACK,
    ST_MACK_END
  } link_st_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_PTR,
    K_DATA
  } byte_kind_e;

  function automatic byte_t map_addr(int i);
    case (i)
      0:       return 8'h09;
      1:       return 8'h0C;
      2:       return 8'h12;
      3:       return 8'h13;
      4:       return 8'h40;
      5:       return 8'h41;
      6:       return 8'h42;
      7:       return 8'h44;
      8:       return 8'h45;
      9:       return 8'h46;
      default: return 8'h47;
    endcase
  endfunction

  function automatic byte_t map_dflt(int i);
    case (i)
      0:       return 8'h13;
      1:       return 8'h08;
      2:       return 8'h08;
      3:       return 8'h80;
      4:       return 8'hC1;
      5:       return 8'h20;
      6:       return 8'h04;
      7:       return 8'h29;
      8:       return 8'h4A;
      9:       return 8'h7F;
      default: return 8'h88;
    endcase
  endfunction

  // bits that ignore writes
  function automatic byte_t map_fmask(int i);
    case (i)
      4:       return 8'hE0;
      9:       return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic byte_t map_fval(int i);
    case (i)
      4:       return 8'hC0;
      9:       return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_edge.sv
`timescale 1ns/100ps
module clkcfg_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int TOP = STAGES;

  // STAGES sync flops plus one history flop
  logic [TOP:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[TOP-1:0], scl_i};
      sda_q <= {sda_q[TOP-1:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_q[TOP-1];
  assign scl_prev = scl_q[TOP];
  assign sda_now  = sda_q[TOP-1];
  assign sda_prev = sda_q[TOP];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/clkcfg_link.sv
`timescale 1ns/100ps
module clkcfg_link
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sda_i,
  input  logic  scl_rise_i,
  input  logic  scl_fall_i,
  input  logic  start_i,
  input  logic  stop_i,
  input  byte_t rd_data_i,
  output byte_t ptr_o,
  output logic  wr_en_o,
  output byte_t wr_data_o,
  output logic  sda_oe_o
);
  link_st_e   st_q;
  byte_kind_e kind_q;
  byte_t      sh_q, ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic       rw_q, nack_q, oe_q;

  logic byte_done;
  assign byte_done = (st_q == ST_RX) && scl_fall_i && (cnt_q == CNT_W'(8));

  assign wr_en_o   = byte_done && (kind_q == K_DATA) && !start_i && !stop_i;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= K_DEV;
      sh_q   <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      st_q   <= ST_RX;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[REG_W-2:0], sda_i};
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (byte_done) begin
            cnt_q <= '0;
            unique case (kind_q)
              K_DEV: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_q <= sh_q[0];
                  oe_q <= 1'b1;
                  st_q <= ST_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              K_PTR: begin
                ptr_q <= sh_q;
                oe_q  <= 1'b1;
                st_q  <= ST_ACK;
              end
              default: begin
                ptr_q <= ptr_q + 8'd1;
                oe_q  <= 1'b1;
                st_q  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: if (scl_rise_i) st_q <= ST_ACK_END;
        ST_ACK_END: begin
          if (scl_fall_i) begin
            if (kind_q == K_DEV && rw_q) begin
              sh_q  <= rd_data_i;
              ptr_q <= ptr_q + 8'd1;
              oe_q  <= ~rd_data_i[7];
              cnt_q <= '0;
              st_q  <= ST_TX;
            end else begin
              oe_q   <= 1'b0;
              st_q   <= ST_RX;
              kind_q <= (kind_q == K_DEV) ? K_PTR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == CNT_W'(7)) begin
              oe_q <= 1'b0;
              st_q <= ST_MACK;
            end else begin
              sh_q  <= {sh_q[REG_W-2:0], 1'b0};
              oe_q  <= ~sh_q[6];
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            nack_q <= sda_i;
            st_q   <= ST_MACK_END;
          end
        end
        ST_MACK_END: begin
          if (scl_fall_i) begin
            if (nack_q) begin
              st_q <= ST_IDLE;
            end else begin
              sh_q  <= rd_data_i;
              ptr_q <= ptr_q + 8'd1;
              oe_q  <= ~rd_data_i[7];
              cnt_q <= '0;
              st_q  <= ST_TX;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkcfg_regbank.sv
`timescale 1ns/100ps
module clkcfg_regbank
  import clkcfg_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  byte_t                     addr_i,
  input  byte_t                     wr_data_i,
  output byte_t                     rd_data_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  byte_t q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam byte_t ADDR  = map_addr(i);
    localparam byte_t DFLT  = map_dflt(i);
    localparam byte_t FMASK = map_fmask(i);
    localparam byte_t FVAL  = map_fval(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[i] <= DFLT;
      end else if (wr_en_i && addr_i == ADDR) begin
        q[i] <= (wr_data_i & ~FMASK) | (FVAL & FMASK);
      end
    end

    assign regs_o[i*REG_W +: REG_W] = q[i];
  end

  // unmapped addresses read zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == map_addr(i)) rd_data_o = q[i];
    end
  end
endmodule

// File: rtl/clkcfg_slave.sv
`timescale 1ns/100ps
module clkcfg_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  logic  sda_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic  wr_en_w;
  byte_t ptr_w, wr_data_w, rd_data_w;

  clkcfg_edge #(
    .STAGES(SYNC_STAGES)
  ) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_w),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  clkcfg_link #(
    .DEV_ADDR(DEV_ADDR)
  ) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_w),
    .scl_rise_i (scl_rise_w),
    .scl_fall_i (scl_fall_w),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .rd_data_i  (rd_data_w),
    .ptr_o      (ptr_w),
    .wr_en_o    (wr_en_w),
    .wr_data_o  (wr_data_w),
    .sda_oe_o   (sda_oe_o)
  );

  clkcfg_regbank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_w),
    .addr_i    (ptr_w),
    .wr_data_i (wr_data_w),
    .rd_data_o (rd_data_w),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/clkcfg_slave_chk.sv
`timescale 1ns/100ps
module clkcfg_slave_chk
  import clkcfg_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      scl_fall_i,
  input logic                      start_i,
  input logic                      stop_i,
  input logic                      sda_oe_i,
  input logic [NUM_REGS*REG_W-1:0] regs_i
);
  // R11
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  // R1
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  // R11
  oe_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> $past(scl_fall_i || start_i || stop_i));

  // R4
  write_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_i) |-> $past(scl_fall_i));

  // R9
  fixed_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_i[4*REG_W+5 +: 3] == 3'b110);

  // R9
  fixed_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_i[9*REG_W +: 6] == 6'h3F);
endmodule

bind clkcfg_slave clkcfg_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_fall_i (scl_fall_w),
  .start_i    (start_w),
  .stop_i     (stop_w),
  .sda_oe_i   (sda_oe_o),
  .regs_i     (regs_o)
);

// File: tb/clkcfg_slave_bench.sv
`timescale 1ns/100ps
module clkcfg_slave_bench;
  localparam int Q     = 16;
  localparam int NR    = 11;
  localparam logic [6:0] DEV = 7'h6A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [NR*8-1:0] regs;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [8];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  clkcfg_slave u_clkcfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  function automatic logic [7:0] e_addr(int i);
    case (i)
      0: return 8'h09;  1: return 8'h0C;  2: return 8'h12;  3: return 8'h13;
      4: return 8'h40;  5: return 8'h41;  6: return 8'h42;  7: return 8'h44;
      8: return 8'h45;  9: return 8'h46;  default: return 8'h47;
    endcase
  endfunction

  function automatic logic [7:0] e_dflt(int i);
    case (i)
      0: return 8'h13;  1: return 8'h08;  2: return 8'h08;  3: return 8'h80;
      4: return 8'hC1;  5: return 8'h20;  6: return 8'h04;  7: return 8'h29;
      8: return 8'h4A;  9: return 8'h7F;  default: return 8'h88;
    endcase
  endfunction

  function automatic int e_idx(logic [7:0] a);
    for (int i = 0; i < NR; i++) if (e_addr(i) == a) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) model[a] = 8'h00;
    for (int i = 0; i < NR; i++) model[e_addr(i)] = e_dflt(i);
  endtask

  // R7 holes, R9 fixed bits
  task automatic model_write(logic [7:0] a, logic [7:0] d);
    int k = e_idx(a);
    if (k < 0) return;
    if (a == 8'h40) d = {3'b110, d[4:0]};
    if (a == 8'h46) d = {d[7:6], 6'h3F};
    model[a] = d;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < NR; i++)
      chk(req, $sformatf("regs_o slot %0d", i), 32'(regs[i*8 +: 8]), 32'(model[e_addr(i)]));
  endtask

  task automatic wait_q(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wait_q(); scl_m = 1'b1; wait_q(2); scl_m = 1'b0; wait_q();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q(); b = sda_bus; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(~mack);
  endtask

  task automatic wr_burst(logic [7:0] a, int n);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R3", "address ack", 32'(ack), 1);
    send_byte(a, ack);           chk("R3", "pointer ack", 32'(ack), 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      chk("R7", "data ack", 32'(ack), 1);
      model_write(a + 8'(k), wbuf[k]);
    end
    bus_stop();
  endtask

  task automatic rd_burst(logic [7:0] a, int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R2", "address ack", 32'(ack), 1);
    send_byte(a, ack);           chk("R3", "pointer ack", 32'(ack), 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R5", "read address ack", 32'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k != n - 1);
      chk("R5", $sformatf("read data at %0h", a + 8'(k)), 32'(d), 32'(model[a + 8'(k)]));
    end
    bus_stop();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'h5EED_C10C));
    model_reset();
    repeat (10) @(negedge clk);
    chk("R11", "oe during reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_regs("R8");
    chk("R10", "slot 0 holds 0x09", 32'(regs[7:0]), 32'h13);

    // R2 wrong device address, then traffic must be ignored
    bus_start();
    send_byte(8'hAA, ack); chk("R2", "mismatch ack", 32'(ack), 0);
    send_byte(8'h09, ack); chk("R2", "ignored pointer ack", 32'(ack), 0);
    send_byte(8'h55, ack); chk("R2", "ignored data ack", 32'(ack), 0);
    bus_stop();
    check_regs("R2");

    // R4 single write, R5 read back
    wbuf[0] = 8'h2A; wr_burst(8'h09, 1);
    check_regs("R4");
    rd_burst(8'h09, 1);

    // R4 R7 R9 burst across the hole at 0x43
    for (int k = 0; k < 8; k++) wbuf[k] = 8'h00;
    wbuf[1] = 8'h5C; wbuf[3] = 8'hEE; wbuf[7] = 8'h91;
    wr_burst(8'h40, 8);
    check_regs("R9");
    chk("R9", "0x40 fixed bits", 32'(regs[4*8 +: 8]), 32'hC0);
    chk("R9", "0x46 fixed bits", 32'(regs[9*8 +: 8]), 32'h3F);
    rd_burst(8'h40, 8);

    // R7 reserved reads
    rd_burst(8'h00, 2);

    // R6 NACK then repeated start continues normally
    bus_start();
    send_byte({DEV, 1'b0}, ack); send_byte(8'h09, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(d, 1'b0);
    chk("R6", "nacked byte", 32'(d), 32'(model[8'h09]));
    chk("R6", "line released after nack", 32'(sda_oe), 0);
    recv_bit(ack);
    chk("R6", "no drive while waiting", 32'(ack), 1);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R6", "ack after restart", 32'(ack), 1);
    send_byte(8'h0C, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(d, 1'b0);
    chk("R6", "read after restart", 32'(d), 32'(model[8'h0C]));
    bus_stop();

    // R1 start cuts a data byte short
    bus_start();
    send_byte({DEV, 1'b0}, ack); send_byte(8'h13, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R1", "ack after abort", 32'(ack), 1);
    bus_stop();
    check_regs("R1");

    // R4 pointer wraps from 0xFF to 0x00 (both holes)
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wr_burst(8'hFF, 2);
    check_regs("R7");

    // random bursts
    for (int it = 0; it < 14; it++) begin
      logic [7:0] base;
      int len;
      base = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                         : e_addr($urandom_range(0, NR - 1));
      len = $urandom_range(1, 4);
      for (int k = 0; k < len; k++) wbuf[k] = 8'($urandom);
      wr_burst(base, len);
      check_regs("R4");
      rd_burst(e_addr($urandom_range(0, NR - 1)), $urandom_range(1, 3));
    end

    // R8 reset restores defaults
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    model_reset();
    check_regs("R8");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule